// File: doc/BRIEF.md
# Dual-Rail Self-Checking Lockstep Comparator

This block watches two equal-width words, typically the already-aligned output bundles of a primary core and its shadow, and raises a sticky error when they differ. The compare result is never carried on a single wire. Each of two independent comparator copies emits its verdict as a complementary rail pair. A pair that collapses to 00 or 11, or two copies that disagree, shows that the comparator itself is broken. That case is reported on its own error output, separate from the divergence output.

A built-in sequencer proves that the comparator is alive. In the first cycle after reset, and then on a programmable schedule, it forces bit 0 of the primary operand to the inverse of the shadow's bit 0 for exactly one cycle. Both copies must then report a mismatch. If they do, a self-test pass status is set. If the mismatch is not seen within two cycles, the comparator is declared dead. The forced mismatch never counts as a real divergence.

The two errors are sticky until reset. The pass status tracks the outcome of the latest self-test.

Top module: `dualrail_lockstep_cmp`

## Requirements
- R1: Each comparator copy encodes "words equal" as rail pair 01 and "words differ" as 10 (bit 1 is the mismatch rail). One clock edge after a cycle in which both copies report 10 outside an injection cycle, `diverge_o` goes to 1 and stays 1 until reset. Equal words never set it.
- R2: A rail pair of 00 or 11 from either copy sets `cmp_fault_o` at the next clock edge, sticky until reset.
- R3: If the two copies give different valid pairs, `cmp_fault_o` is set at the next clock edge, sticky until reset.
- R4: An injection cycle forces bit 0 of the compared primary word to the inverse of `chk_i[0]` for exactly one cycle. The forced mismatch exists even when the inputs already differ only in bit 0.
- R5: The first injection cycle is the cycle that ends at the first clock edge after reset release. After each passed test, the next injection cycle ends `period_i + 3` edges after the previous one. `period_i` is sampled when a test completes.
- R6: When both copies report a mismatch in the injection cycle, `selftest_ok_o` is 1 after the second edge following that cycle.
- R7: If the injected mismatch is not seen, `cmp_fault_o` goes to 1 and `selftest_ok_o` goes to 0 at the third edge counted from the injection cycle's edge (two cycles of waiting).
- R8: A mismatch present only in an injection cycle never sets `diverge_o`. A divergence that persists into the following cycle is reported one edge after that cycle.
- R9: While `rst_n` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| prim_i | input | DATA_W (32) | Word from the primary channel |
| chk_i | input | DATA_W (32) | Word from the shadow channel |
| period_i | input | PER_W (16) | Idle cycles between self-tests, minus overhead |
| diverge_o | output | 1 | Sticky: the channels diverged |
| cmp_fault_o | output | 1 | Sticky: comparator broken or self-test missed |
| selftest_ok_o | output | 1 | Latest self-test passed |

## Verification
A genuine channel divergence and a scheduled fault injection can land in the same cycle. In that cycle the divergence mask must suppress the real error as well as the injected one. The bench counts clock edges from reset release, so it knows exactly which cycles are injection cycles. It then presents a top-bit divergence for only that cycle, and separately for that cycle plus the next. It expects `diverge_o` to stay low in the first case and to rise one edge after the second cycle in the other case. In both cases the self-test must still pass with no comparator fault. A bit-0-only difference placed in an injection cycle checks that the injection cannot cancel itself out.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam logic [1:0] RAIL_SAME = 2'b01;
    localparam logic [1:0] RAIL_DIFF = 2'b10;

    typedef enum logic [1:0] {
        SEQ_INJ  = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_IDLE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic diverge;
        logic fault;
        logic inj_hit;
    } judge_state_t;

endpackage

// File: rtl/drc_rail_cmp.sv
module drc_rail_cmp #(
    parameter int DATA_W  = 32,
    parameter int VARIANT = 0
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [1:0]        rail_o
);
    logic mis;

    generate
        if (VARIANT == 0) begin : g_xor_reduce
            assign mis = |(a_i ^ b_i);
        end else begin : g_equality
            assign mis = (a_i != b_i);
        end
    endgenerate

    assign rail_o = {mis, ~mis};
endmodule

// File: rtl/drc_judge.sv
module drc_judge
    import drc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rail_a_i,
    input  logic [1:0] rail_b_i,
    input  logic       inject_i,
    input  logic       dead_i,
    output logic       diverge_o,
    output logic       fault_o,
    output logic       inj_hit_o
);
    judge_state_t st_d, st_q;
    logic a_ok, b_ok, split, both_diff;

    always_comb begin
        a_ok      = rail_a_i[1] ^ rail_a_i[0];
        b_ok      = rail_b_i[1] ^ rail_b_i[0];
        split     = (rail_a_i != rail_b_i);
        both_diff = a_ok && b_ok && !split && (rail_a_i == RAIL_DIFF);

        st_d         = st_q;
        st_d.diverge = st_q.diverge | (both_diff & ~inject_i);
        st_d.fault   = st_q.fault | ~a_ok | ~b_ok | split | dead_i;
        st_d.inj_hit = inject_i & both_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign diverge_o = st_q.diverge;
    assign fault_o   = st_q.fault;
    assign inj_hit_o = st_q.inj_hit;

    assert_diverge_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_a_i == RAIL_DIFF && rail_b_i == RAIL_DIFF && !inject_i) |=> diverge_o);

    assert_diverge_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        diverge_o |=> diverge_o);

    assert_rail_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_a_i == 2'b00) || (rail_a_i == 2'b11) ||
         (rail_b_i == 2'b00) || (rail_b_i == 2'b11)) |=> fault_o);

    assert_copies_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_a_i != rail_b_i) |=> fault_o);

    assert_inject_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(diverge_o) |-> !$past(inject_i));
endmodule

// File: rtl/drc_selftest_seq.sv
module drc_selftest_seq
    import drc_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    input  logic             inj_hit_i,
    output logic             inject_o,
    output logic             dead_o,
    output logic             pass_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [PER_W-1:0] cnt;
        logic             win;
        logic             pass;
    } seq_t;

    seq_t sq_d, sq_q;
    logic miss;

    always_comb begin
        sq_d = sq_q;
        miss = 1'b0;
        unique case (sq_q.st)
            SEQ_INJ: begin
                sq_d.st  = SEQ_WAIT;
                sq_d.win = 1'b0;
            end
            SEQ_WAIT: begin
                if (inj_hit_i) begin
                    sq_d.pass = 1'b1;
                    sq_d.st   = SEQ_IDLE;
                    sq_d.cnt  = period_i;
                end else if (sq_q.win) begin
                    miss      = 1'b1;
                    sq_d.pass = 1'b0;
                    sq_d.st   = SEQ_IDLE;
                    sq_d.cnt  = period_i;
                end else begin
                    sq_d.win  = 1'b1;
                end
            end
            SEQ_IDLE: begin
                if (sq_q.cnt == '0) sq_d.st  = SEQ_INJ;
                else                sq_d.cnt = sq_q.cnt - 1'b1;
            end
            default: sq_d.st = SEQ_INJ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q.st   <= SEQ_INJ;
            sq_q.cnt  <= '0;
            sq_q.win  <= 1'b0;
            sq_q.pass <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign inject_o = (sq_q.st == SEQ_INJ);
    assign dead_o   = miss;
    assign pass_o   = sq_q.pass;

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inject_o |=> !inject_o);
endmodule

// File: rtl/dualrail_lockstep_cmp.sv
module dualrail_lockstep_cmp #(
    parameter int DATA_W = 32,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] prim_i,
    input  logic [DATA_W-1:0] chk_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              diverge_o,
    output logic              cmp_fault_o,
    output logic              selftest_ok_o
);
    logic [DATA_W-1:0] prim_eff;
    logic [1:0]        rail_a_w;
    logic [1:0]        rail_b_w;
    logic              inject_w, dead_w, inj_hit_w;

    // R4: bit 0 forced opposite to the shadow during an injection cycle
    assign prim_eff = {prim_i[DATA_W-1:1], inject_w ? ~chk_i[0] : prim_i[0]};

    drc_rail_cmp #(.DATA_W(DATA_W), .VARIANT(0)) u_cmp_a (
        .a_i(prim_eff), .b_i(chk_i), .rail_o(rail_a_w)
    );

    drc_rail_cmp #(.DATA_W(DATA_W), .VARIANT(1)) u_cmp_b (
        .a_i(prim_eff), .b_i(chk_i), .rail_o(rail_b_w)
    );

    drc_judge u_judge (
        .clk(clk), .rst_n(rst_n),
        .rail_a_i(rail_a_w), .rail_b_i(rail_b_w),
        .inject_i(inject_w), .dead_i(dead_w),
        .diverge_o(diverge_o), .fault_o(cmp_fault_o), .inj_hit_o(inj_hit_w)
    );

    drc_selftest_seq #(.PER_W(PER_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .period_i(period_i), .inj_hit_i(inj_hit_w),
        .inject_o(inject_w), .dead_o(dead_w), .pass_o(selftest_ok_o)
    );

    assert_pass_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_hit_w |=> selftest_ok_o);

    assert_dead_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dead_w |=> (cmp_fault_o && !selftest_ok_o));
endmodule

// File: tb/dualrail_lockstep_cmp_bench.sv
`timescale 1ns/1ps
module dualrail_lockstep_cmp_bench;
    localparam int BW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] prim = '0;
    logic [BW-1:0] chk = '0;
    logic [PW-1:0] period = 16'd1000;
    logic          diverge, cmp_fault, st_ok;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    dualrail_lockstep_cmp #(.DATA_W(BW), .PER_W(PW)) u_dualrail_lockstep_cmp (
        .clk(clk), .rst_n(rst_n), .prim_i(prim), .chk_i(chk), .period_i(period),
        .diverge_o(diverge), .cmp_fault_o(cmp_fault), .selftest_ok_o(st_ok)
    );

    // {prim, chk, expected diverge}
    localparam logic [2*BW:0] VEC [7] = '{
        {32'h0000_0000, 32'h0000_0000, 1'b0},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
        {32'hA5A5_0F0F, 32'hA5A5_0F0F, 1'b0},
        {32'h0000_0001, 32'h0000_0000, 1'b1},
        {32'h8000_0000, 32'h0000_0000, 1'b1},
        {32'h1234_5678, 32'h1234_D678, 1'b1},
        {32'hDEAD_BEEF, 32'h2152_4110, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edges);
        end
    endtask

    task automatic goto(input int n);
        while (edges < n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [PW-1:0] per);
        @(negedge clk);
        rst_n  = 1'b0;
        prim   = '0;
        chk    = '0;
        period = per;
        repeat (3) @(negedge clk);
        check("R9 diverge in reset", {31'd0, diverge}, 32'd0);
        check("R9 fault in reset", {31'd0, cmp_fault}, 32'd0);
        check("R9 ok in reset", {31'd0, st_ok}, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        // table walk: R1 encoding and stickiness
        for (int i = 0; i < 7; i++) begin
            do_reset(16'd1000);
            goto(1);
            check("R6 ok not yet after first edge", {31'd0, st_ok}, 32'd0);
            goto(2);
            check("R6 ok after first test", {31'd0, st_ok}, 32'd1);
            prim = VEC[i][2*BW:BW+1];
            chk  = VEC[i][BW:1];
            goto(3);
            check("R1 diverge from vector", {31'd0, diverge}, {31'd0, VEC[i][0]});
            check("R1 no comparator fault", {31'd0, cmp_fault}, 32'd0);
            prim = '0;
            chk  = '0;
            goto(5);
            check("R1 diverge sticky", {31'd0, diverge}, {31'd0, VEC[i][0]});
        end

        // R4, R5, R8: period 5 gives injection cycles ending at edges 1, 9, 17, 25
        do_reset(16'd5);
        chk  = 32'h0F0F_0F0E;
        prim = 32'h0F0F_0F0E;
        goto(8);
        prim = chk ^ 32'h1;           // differs only in bit 0 during injection
        goto(9);
        prim = chk;
        check("R8 bit0 diff in injection cycle masked", {31'd0, diverge}, 32'd0);
        goto(10);
        check("R4 injection not cancelled by bit0 diff", {31'd0, st_ok}, 32'd1);
        check("R4 no fault from bit0 diff", {31'd0, cmp_fault}, 32'd0);
        goto(16);
        prim = chk ^ 32'h8000_0000;   // one-cycle divergence only in injection cycle
        goto(17);
        prim = chk;
        goto(18);
        check("R8 single-cycle divergence on injection masked", {31'd0, diverge}, 32'd0);
        check("R5 test at edge 17 passed", {31'd0, st_ok}, 32'd1);
        goto(24);
        prim = chk ^ 32'h8000_0000;   // divergence held over injection and next cycle
        goto(25);
        check("R8 masked in injection cycle", {31'd0, diverge}, 32'd0);
        goto(26);
        check("R8 persisted divergence reported", {31'd0, diverge}, 32'd1);
        check("R8 self-test still passed", {31'd0, st_ok}, 32'd1);
        check("R8 no comparator fault", {31'd0, cmp_fault}, 32'd0);
        prim = chk;

        // R7 and R5: rails stuck at "equal", caught only by the test ending at edge 9
        do_reset(16'd5);
        goto(2);
        check("R6 ok before stuck fault", {31'd0, st_ok}, 32'd1);
        goto(3);
        force u_dualrail_lockstep_cmp.rail_a_w = 2'b01;
        force u_dualrail_lockstep_cmp.rail_b_w = 2'b01;
        goto(8);
        check("R5 no test before edge 9", {31'd0, cmp_fault}, 32'd0);
        check("R5 ok held until next test", {31'd0, st_ok}, 32'd1);
        goto(10);
        check("R7 fault not before window end", {31'd0, cmp_fault}, 32'd0);
        goto(11);
        check("R7 dead comparator flagged", {31'd0, cmp_fault}, 32'd1);
        check("R7 ok cleared", {31'd0, st_ok}, 32'd0);
        release u_dualrail_lockstep_cmp.rail_a_w;
        release u_dualrail_lockstep_cmp.rail_b_w;

        // R2: collapsed rail pair
        do_reset(16'd1000);
        goto(2);
        force u_dualrail_lockstep_cmp.rail_a_w = 2'b11;
        goto(3);
        release u_dualrail_lockstep_cmp.rail_a_w;
        check("R2 rail 11 flagged", {31'd0, cmp_fault}, 32'd1);
        check("R2 no divergence", {31'd0, diverge}, 32'd0);
        goto(5);
        check("R2 fault sticky", {31'd0, cmp_fault}, 32'd1);

        do_reset(16'd1000);
        goto(2);
        force u_dualrail_lockstep_cmp.rail_b_w = 2'b00;
        goto(3);
        release u_dualrail_lockstep_cmp.rail_b_w;
        check("R2 rail 00 flagged", {31'd0, cmp_fault}, 32'd1);

        // R3: copies disagree with valid codes
        do_reset(16'd1000);
        goto(2);
        force u_dualrail_lockstep_cmp.rail_b_w = 2'b10;
        goto(3);
        release u_dualrail_lockstep_cmp.rail_b_w;
        check("R3 copy split flagged", {31'd0, cmp_fault}, 32'd1);
        check("R3 split not divergence", {31'd0, diverge}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule